// File: doc/BRIEF.md
# Transfer-Completion Interrupt Aggregator

This block merges transfer-completion reports from several data-movement channels into one interrupt line for the processor. In any cycle, each channel may report a completion. A report carries an interrupt-request option bit and a completion code. The code is chosen when the transfer is programmed and is not tied to the channel number. A report whose option bit is set marks the pending bit selected by its code, in a pending register with one bit per code.

A second register of the same width holds the enables. The interrupt output is a registered level. It is high whenever a pending bit and its enable are both set, and it stays high until software clears every enabled pending bit. Software changes the block through a write port. A 2-bit operation selects one of three actions: set enables, clear enables, or clear pending bits. Each action applies to the bits that are one in the write word. The pending and enable registers are brought out so the processor can read them.

Top module: `tc_done_irq_ctrl`

## Requirements
- R1: While rst_ni is low, pend_o, en_o and irq_o are all zero.
- R2: A report with done_valid_i[c] = 1 and done_ien_i[c] = 1 sets pend_o[k] at the next rising edge. Here k is the CODE_W-bit field done_code_i[c*CODE_W +: CODE_W], and the channel number c plays no part in the selection.
- R3: A report with done_ien_i[c] = 0, or with done_valid_i[c] = 0, sets no pending bit.
- R4: All reports in one cycle are recorded, whatever their codes. Reports that share a code set that one bit.
- R5: When wr_op_i = 3 (pending clear), each bit that is one in wr_data_i clears the matching pending bit. No other pending bit changes, and pending bits never drop under any other operation.
- R6: When a report and a pending clear hit the same bit in the same cycle, the bit remains set.
- R7: wr_op_i = 1 ORs wr_data_i into the enables. wr_op_i = 2 clears the enables where wr_data_i is one. wr_op_i = 0 leaves the enables unchanged.
- R8: After every rising edge, irq_o equals the OR of (pend_o AND en_o). It is updated at the same edge as the registers and is not delayed by an extra cycle.
- R9: A report whose code has its enable at zero still sets the pending bit, but it does not raise irq_o. Setting that enable later raises irq_o at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| done_valid_i | input | NUM_CH | Per-channel completion report strobe |
| done_ien_i | input | NUM_CH | Per-report interrupt-request option bit |
| done_code_i | input | NUM_CH*CODE_W | Completion code of each report, channel c at bits c*CODE_W |
| wr_op_i | input | 2 | 0 none, 1 set enables, 2 clear enables, 3 clear pending |
| wr_data_i | input | 2**CODE_W | Bit mask for the write operation |
| pend_o | output | 2**CODE_W | Pending register |
| en_o | output | 2**CODE_W | Enable register |
| irq_o | output | 1 | Registered global interrupt level |

## Verification
The bench builds the block with four reporting channels and 6-bit codes, which gives 64 pending and enable bits. With four channels, one cycle can carry reports with distinct codes, reports that collide on a code, and a report and a clear that land on the same bit. The 64-bit registers make the highest code, 63, reachable as a directed corner. The random phase mixes every write operation with bursts of reports, so interrupt masking and unmasking is exercised on many bit positions.

// File: rtl/tcic_pkg.sv
package tcic_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_EN_SET   = 2'd1,
    OP_EN_CLR   = 2'd2,
    OP_PEND_CLR = 2'd3
  } wr_op_e;
endpackage

// File: rtl/tcic_hit_decode.sv
module tcic_hit_decode #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 6,
  localparam int NUM_CODE = 1 << CODE_W
) (
  input  logic [NUM_CH-1:0]        valid_i,
  input  logic [NUM_CH-1:0]        ien_i,
  input  logic [NUM_CH*CODE_W-1:0] code_i,
  output logic [NUM_CODE-1:0]      hit_o
);
  logic [NUM_CODE-1:0] onehot [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] code;
    assign code = code_i[c*CODE_W +: CODE_W];
    always_comb begin
      onehot[c] = '0;
      if (valid_i[c] && ien_i[c]) onehot[c][code] = 1'b1;
    end
  end

  always_comb begin
    hit_o = '0;
    for (int c = 0; c < NUM_CH; c++) hit_o = hit_o | onehot[c];
  end
endmodule

// File: rtl/tcic_bitreg.sv
module tcic_bitreg #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] q;

  // set beats clear on the same bit
  assign nxt_o = (q & ~clr_i) | set_i;
  assign q_o   = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt_o;
  end
endmodule

// File: rtl/tc_done_irq_ctrl.sv
module tc_done_irq_ctrl
  import tcic_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 6,
  localparam int NUM_CODE = 1 << CODE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        done_valid_i,
  input  logic [NUM_CH-1:0]        done_ien_i,
  input  logic [NUM_CH*CODE_W-1:0] done_code_i,
  input  logic [1:0]               wr_op_i,
  input  logic [NUM_CODE-1:0]      wr_data_i,
  output logic [NUM_CODE-1:0]      pend_o,
  output logic [NUM_CODE-1:0]      en_o,
  output logic                     irq_o
);
  wr_op_e              op;
  logic [NUM_CODE-1:0] hit;
  logic [NUM_CODE-1:0] pend_clr, en_set, en_clr;
  logic [NUM_CODE-1:0] pend_nxt, en_nxt;
  logic                irq_q;

  assign op = wr_op_e'(wr_op_i);

  tcic_hit_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
    .valid_i (done_valid_i),
    .ien_i   (done_ien_i),
    .code_i  (done_code_i),
    .hit_o   (hit)
  );

  always_comb begin
    pend_clr = '0;
    en_set   = '0;
    en_clr   = '0;
    unique case (op)
      OP_EN_SET:   en_set   = wr_data_i;
      OP_EN_CLR:   en_clr   = wr_data_i;
      OP_PEND_CLR: pend_clr = wr_data_i;
      default: ;
    endcase
  end

  tcic_bitreg #(.WIDTH(NUM_CODE)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (pend_clr),
    .q_o    (pend_o),
    .nxt_o  (pend_nxt)
  );

  tcic_bitreg #(.WIDTH(NUM_CODE)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .q_o    (en_o),
    .nxt_o  (en_nxt)
  );

  // level computed from next state so it moves with the registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_nxt & en_nxt);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tcic_checker.sv
module tcic_checker #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 6,
  localparam int NUM_CODE = 1 << CODE_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CH-1:0]        done_valid_i,
  input logic [NUM_CH-1:0]        done_ien_i,
  input logic [NUM_CH*CODE_W-1:0] done_code_i,
  input logic [1:0]               wr_op_i,
  input logic [NUM_CODE-1:0]      wr_data_i,
  input logic [NUM_CODE-1:0]      pend_o,
  input logic [NUM_CODE-1:0]      en_o,
  input logic                     irq_o
);
  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (pend_o == '0 && en_o == '0 && !irq_o); // R1
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_set
    AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_valid_i[c] && done_ien_i[c]) |=> pend_o[$past(done_code_i[c*CODE_W +: CODE_W])]); // R2
  end

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_valid_i & done_ien_i) == '0) |=> ((pend_o & ~$past(pend_o)) == '0)); // R3

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_op_i != 2'd3) |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R5

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_op_i == 2'd1) |=> ((en_o & $past(wr_data_i)) == $past(wr_data_i))); // R7

  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_op_i == 2'd2) |=> ((en_o & $past(wr_data_i)) == '0)); // R7

  AST_EN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_op_i == 2'd0) |=> $stable(en_o)); // R7

  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(pend_o & en_o)); // R8
endmodule

bind tc_done_irq_ctrl tcic_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_tc_done_irq_ctrl.sv
module tb_tc_done_irq_ctrl;
  localparam int NUM_CH   = 4;
  localparam int CODE_W   = 6;
  localparam int NUM_CODE = 1 << CODE_W;

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic [NUM_CH-1:0]        done_valid_i = '0;
  logic [NUM_CH-1:0]        done_ien_i = '0;
  logic [NUM_CH*CODE_W-1:0] done_code_i = '0;
  logic [1:0]               wr_op_i = '0;
  logic [NUM_CODE-1:0]      wr_data_i = '0;
  logic [NUM_CODE-1:0]      pend_o, en_o;
  logic                     irq_o;

  logic [NUM_CODE-1:0] m_pend = '0, m_en = '0;
  logic                m_irq = 1'b0;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tc_done_irq_ctrl #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) dut (.*);

  function automatic logic [NUM_CODE-1:0] f_hits(
      logic [NUM_CH-1:0] v, logic [NUM_CH-1:0] ie, logic [NUM_CH*CODE_W-1:0] cd);
    logic [NUM_CODE-1:0] h = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (v[c] && ie[c]) h[cd[c*CODE_W +: CODE_W]] = 1'b1;
    return h;
  endfunction

  task automatic chk(string tag, logic [NUM_CODE-1:0] act, logic [NUM_CODE-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " pend"}, pend_o, m_pend);
    chk({tag, " en"}, en_o, m_en);
    chk({tag, " irq R8"}, {63'd0, irq_o}, {63'd0, m_irq});
  endtask

  // drive one cycle of stimulus, advance the model, check after the edge
  task automatic step(logic [NUM_CH-1:0] v, logic [NUM_CH-1:0] ie,
                      logic [NUM_CH*CODE_W-1:0] cd, logic [1:0] op,
                      logic [NUM_CODE-1:0] wd, string tag);
    logic [NUM_CODE-1:0] h;
    @(negedge clk_i);
    done_valid_i = v; done_ien_i = ie; done_code_i = cd; wr_op_i = op; wr_data_i = wd;
    h = f_hits(v, ie, cd);
    m_pend = (m_pend & ~((op == 2'd3) ? wd : '0)) | h;
    if (op == 2'd1) m_en = m_en | wd;
    if (op == 2'd2) m_en = m_en & ~wd;
    m_irq = |(m_pend & m_en);
    @(posedge clk_i);
    #1;
    check_all(tag);
  endtask

  function automatic logic [NUM_CH*CODE_W-1:0] codes(int a, int b, int c, int d);
    return {CODE_W'(d), CODE_W'(c), CODE_W'(b), CODE_W'(a)};
  endfunction

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk_i);
    check_all("R1 reset");
    rst_ni = 1'b1;

    // R2: highest code from channel 2, channel number unrelated to bit
    step(4'b0100, 4'b0100, codes(0, 0, 63, 0), 2'd0, '0, "R2 code63");
    // R3: ien low or valid low records nothing
    step(4'b0001, 4'b0000, codes(5, 0, 0, 0), 2'd0, '0, "R3 ien0");
    step(4'b0000, 4'b1111, codes(9, 9, 9, 9), 2'd0, '0, "R3 valid0");
    // R4: four distinct codes at once, then a collision
    step(4'b1111, 4'b1111, codes(1, 2, 3, 4), 2'd0, '0, "R4 distinct");
    step(4'b0011, 4'b0011, codes(7, 7, 0, 0), 2'd0, '0, "R4 collide");
    // R5: clear bits 1 and 2 only
    step('0, '0, '0, 2'd3, 64'h6, "R5 clear");
    // R6: report and clear on bit 3 together
    step(4'b1000, 4'b1000, codes(0, 0, 0, 3), 2'd3, 64'h8, "R6 race");
    // R9: bit 63 pending, enable low, irq stays low
    step('0, '0, '0, 2'd0, '0, "R9 masked");
    // R7 / R9: enable bit 63 raises irq at the same edge
    step('0, '0, '0, 2'd1, 64'h8000_0000_0000_0000, "R9 unmask R7 set");
    step('0, '0, '0, 2'd2, 64'h8000_0000_0000_0000, "R7 clear en");
    step('0, '0, '0, 2'd3, '1, "R5 clear all");

    for (int i = 0; i < 3000; i++) begin
      logic [NUM_CH*CODE_W-1:0] cd;
      logic [NUM_CODE-1:0] wd;
      logic [1:0] op;
      cd = {$urandom, $urandom};
      wd = {$urandom, $urandom} & {$urandom, $urandom};
      op = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      step(4'($urandom), 4'($urandom), cd, op, wd, "R2 R4 R5 R7 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule